// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave for two address windows in which every 32-bit alias word stands for a single bit of ordinary memory. An upstream master issues a request with an address, a write flag, write data and an access size. The bridge turns the alias address into a real target address and a bit index, and then works on that bit. For a read it fetches the containing byte, halfword or word and returns only the chosen bit. For a write it fetches the unit, sets or clears the chosen bit, and writes the unit back.

The downstream side is a memory master port with a request/ready handshake. The port holds each request steady until the memory accepts it. The read-modify-write cannot be broken up: the bridge accepts no new upstream request from the moment the downstream read is issued until the write-back completes. Each finished access produces a one-cycle ready pulse upstream. The memory and any arbitration in front of it are outside this block.

Top module: `bitalias_bridge`

## Requirements
- R1: A request is accepted only when `req_addr[31:25]` equals 7'h11 (window 0x22000000..0x23FFFFFF) or 7'h21 (window 0x42000000..0x43FFFFFF). Any other address is ignored: no downstream request is made and `rsp_ready` stays low for as long as the request is held.
- R2: Before alignment, the downstream target address is `(req_addr & 32'hE000_0000) | ((req_addr & 32'h01FF_FFFF) >> 5)`. This means target bits [28:20] are always zero.
- R3: Sizes are coded 0 = byte, 1 = halfword, 2 = word, and 3 is handled as word. `mem_size` carries the normalised code. The bit index is `req_addr[4:2]` for a byte, `req_addr[5:2]` for a halfword and `req_addr[6:2]` for a word. A halfword target has address bit 0 cleared, and a word target has address bits [1:0] cleared.
- R4: A read makes exactly one downstream read of the target unit and no write. It returns the selected bit in `rsp_rdata[0]`, with bits [31:1] zero.
- R5: A write reads the unit and then writes it back with the selected bit set when `req_wdata[0]` is 1, or cleared when it is 0. All other bits of the unit and all other bytes of memory are left unchanged, `req_wdata[31:1]` has no effect, and `rsp_rdata` is zero.
- R6: Downstream data is right-justified and little-endian: bit n of a unit is data bit n, and the byte at the lowest address occupies bits [7:0]. Bits of `mem_wdata` above the unit width are zero.
- R7: For a write, the downstream write-back goes to the same address as the read and directly follows it. No other downstream transfer comes between them.
- R8: `rsp_ready` is high for exactly one cycle per completed access. That cycle is the one that follows the final downstream handshake.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_size` keep their values into the next cycle.
- R10: While `rst_n` is low, `rsp_ready` and `mem_req` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present; held until `rsp_ready` |
| req_addr | input | 32 | Alias address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| req_size | input | 2 | Access size code (see R3) |
| rsp_rdata | output | 32 | Read result; selected bit in bit 0 |
| rsp_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Downstream transfer request |
| mem_we | output | 1 | Downstream write flag |
| mem_addr | output | 32 | Downstream byte address |
| mem_size | output | 2 | Downstream unit size code |
| mem_wdata | output | 32 | Downstream write data, right-justified |
| mem_rdata | input | 32 | Downstream read data, right-justified |
| mem_ready | input | 1 | Downstream handshake completion |

## Verification
Several properties are checked on every cycle:
- the ready pulse lasts one cycle and comes only after a downstream handshake;
- a downstream request stays stable while it is stalled;
- halfword and word targets are aligned, and target bits [28:20] are zero;
- a write-back immediately follows a read of the same address;
- a write-back changes at most one bit of the data just read.

Other behaviours can only be shown by the bench's scenarios:
- the exact target address for each alias;
- the bit chosen for each size and index;
- that set and clear land on the right bit with no effect on neighbouring bytes;
- that addresses outside both windows are ignored.

The bench covers these by sweeping every bit index of several units at each size, in both windows, with varying memory latency.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_READ       = 2'd1,
      ST_WRITE_BACK = 2'd2,
      ST_RESPOND    = 2'd3
   } br_state_e;

   // Code 3 is handled as a full word.
   function automatic acc_size_e norm_size(input logic [1:0] code);
      return (code == 2'd3) ? SZ_WORD : acc_size_e'(code);
   endfunction

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode #(
   parameter int ADDR_W   = 32,
   parameter int WIN_LOG2 = 25,
   parameter int NUM_WIN  = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;

   logic [NUM_WIN-1:0] hit_vec;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = WIN_BASES[w*ADDR_W +: ADDR_W];
      if (BASE[WIN_LOG2-1:0] != '0) begin : g_bad_base
         $error("window base not aligned to the window size");
      end
      assign hit_vec[w] = (addr[ADDR_W-1:WIN_LOG2] == BASE[ADDR_W-1 -: TAG_W]);
   end

   assign hit = |hit_vec;

   logic unused_low;
   assign unused_low = ^addr[WIN_LOG2-1:0];

endmodule

// File: rtl/bitalias_xlate.sv
module bitalias_xlate
   import bitalias_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WIN_LOG2    = 25,
   parameter int REGION_LOG2 = 29,
   parameter int BIT_SHIFT   = 5,
   parameter int IDX_W       = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size_code,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [IDX_W-1:0]  bit_idx,
   output acc_size_e         size_n
);
   localparam int BIT_LSB = BIT_SHIFT - 3;

   logic [ADDR_W-1:0] region_part;
   logic [ADDR_W-1:0] offset_part;
   logic [ADDR_W-1:0] raw_tgt;

   assign region_part = {addr[ADDR_W-1:REGION_LOG2], {REGION_LOG2{1'b0}}};
   assign offset_part = ADDR_W'(addr[WIN_LOG2-1:0]) >> BIT_SHIFT;
   assign raw_tgt     = region_part | offset_part;
   assign size_n      = norm_size(size_code);

   always_comb begin
      case (size_n)
         SZ_BYTE: begin
            tgt_addr = raw_tgt;
            bit_idx  = IDX_W'(addr[BIT_LSB+2:BIT_LSB]);
         end
         SZ_HALF: begin
            tgt_addr = {raw_tgt[ADDR_W-1:1], 1'b0};
            bit_idx  = IDX_W'(addr[BIT_LSB+3:BIT_LSB]);
         end
         default: begin
            tgt_addr = {raw_tgt[ADDR_W-1:2], 2'b00};
            bit_idx  = addr[BIT_LSB+IDX_W-1:BIT_LSB];
         end
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{addr[BIT_LSB-1:0], addr[REGION_LOG2-1:WIN_LOG2]};

endmodule

// File: rtl/bitalias_lane.sv
module bitalias_lane
   import bitalias_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  acc_size_e          size_n,
   input  logic [IDX_W-1:0]   bit_idx,
   input  logic [DATA_W-1:0]  unit_rdata,
   input  logic               set_val,
   output logic               sel_bit,
   output logic [DATA_W-1:0]  unit_wdata
);
   logic [DATA_W-1:0] bit_mask;
   logic [DATA_W-1:0] unit_mask;
   logic [DATA_W-1:0] merged;

   assign bit_mask = DATA_W'(1) << bit_idx;

   always_comb begin
      case (size_n)
         SZ_BYTE: unit_mask = DATA_W'(8'hFF);
         SZ_HALF: unit_mask = DATA_W'(16'hFFFF);
         default: unit_mask = '1;
      endcase
   end

   assign sel_bit    = |(unit_rdata & bit_mask);
   assign merged     = set_val ? (unit_rdata | bit_mask) : (unit_rdata & ~bit_mask);
   assign unit_wdata = merged & unit_mask;

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
   import bitalias_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WIN_LOG2    = 25,
   parameter int REGION_LOG2 = 29,
   parameter int BIT_SHIFT   = 5,
   parameter logic [ADDR_W-1:0] WIN0_BASE = 32'h2200_0000,
   parameter logic [ADDR_W-1:0] WIN1_BASE = 32'h4200_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_size,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int IDX_W   = $clog2(DATA_W);
   localparam int NUM_WIN = 2;
   localparam logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {WIN1_BASE, WIN0_BASE};

   if (DATA_W != 32) begin : g_bad_data
      $error("data width must be 32");
   end
   if (BIT_SHIFT != IDX_W) begin : g_bad_shift
      $error("alias shift must equal the bit index width");
   end
   if (REGION_LOG2 <= WIN_LOG2 || REGION_LOG2 >= ADDR_W) begin : g_bad_region
      $error("region field must lie above the window offset");
   end

   logic              win_hit;
   logic [ADDR_W-1:0] xl_addr;
   logic [IDX_W-1:0]  xl_idx;
   acc_size_e         xl_size;

   bitalias_decode #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_WIN(NUM_WIN), .WIN_BASES(WIN_BASES)
   ) decode_i (
      .addr(req_addr), .hit(win_hit)
   );

   bitalias_xlate #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .REGION_LOG2(REGION_LOG2),
      .BIT_SHIFT(BIT_SHIFT), .IDX_W(IDX_W)
   ) xlate_i (
      .addr(req_addr), .size_code(req_size),
      .tgt_addr(xl_addr), .bit_idx(xl_idx), .size_n(xl_size)
   );

   br_state_e         state_q;
   logic              we_q;
   logic              set_q;
   acc_size_e         size_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wb_q;
   logic              bit_q;

   logic              ln_bit;
   logic [DATA_W-1:0] ln_wdata;

   bitalias_lane #(
      .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) lane_i (
      .size_n(size_q), .bit_idx(idx_q), .unit_rdata(mem_rdata), .set_val(set_q),
      .sel_bit(ln_bit), .unit_wdata(ln_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         set_q   <= 1'b0;
         size_q  <= SZ_BYTE;
         idx_q   <= '0;
         addr_q  <= '0;
         wb_q    <= '0;
         bit_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid && win_hit) begin
                  we_q    <= req_we;
                  set_q   <= req_wdata[0];
                  size_q  <= xl_size;
                  idx_q   <= xl_idx;
                  addr_q  <= xl_addr;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (mem_ready) begin
                  wb_q    <= ln_wdata;
                  bit_q   <= we_q ? 1'b0 : ln_bit;
                  state_q <= we_q ? ST_WRITE_BACK : ST_RESPOND;
               end
            end
            ST_WRITE_BACK: begin
               if (mem_ready) begin
                  state_q <= ST_RESPOND;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE_BACK);
   assign mem_we    = (state_q == ST_WRITE_BACK);
   assign mem_addr  = addr_q;
   assign mem_size  = size_q;
   assign mem_wdata = (state_q == ST_WRITE_BACK) ? wb_q : '0;
   assign rsp_ready = (state_q == ST_RESPOND);
   assign rsp_rdata = {{(DATA_W-1){1'b0}}, bit_q};

   logic unused_wdata;
   assign unused_wdata = ^req_wdata[DATA_W-1:1];

endmodule

// File: rtl/bitalias_bridge_chk.sv
module bitalias_bridge_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WIN_LOG2    = 25,
   parameter int REGION_LOG2 = 29,
   parameter int BIT_SHIFT   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_ready
);
   logic [DATA_W-1:0] seen_rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_rd_q <= '0;
      else if (mem_req && mem_ready && !mem_we) seen_rd_q <= mem_rdata;
   end

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready); // R8
   AST_READY_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> $past(mem_req && mem_ready)); // R8
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_size))); // R9
   AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> (rsp_rdata[DATA_W-1:1] == '0)); // R4
   AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == 2'd1) |-> !mem_addr[0]); // R3
   AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00)); // R3
   AST_TGT_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[REGION_LOG2-1:WIN_LOG2-BIT_SHIFT] == '0)); // R2
   AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !$past(mem_req && mem_we)) |->
         ($past(mem_req && !mem_we && mem_ready) && $stable(mem_addr))); // R7
   AST_WB_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_wdata ^ seen_rd_q) <= 1)); // R5

endmodule

bind bitalias_bridge bitalias_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2),
   .REGION_LOG2(REGION_LOG2), .BIT_SHIFT(BIT_SHIFT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
   .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
);

// File: tb/bitalias_bridge_tb_top.sv
module bitalias_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_we = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_ready;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ready;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bitalias_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_we(req_we), .req_wdata(req_wdata), .req_size(req_size),
      .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // Memory model: 64 bytes indexed by the low address bits, latency 0..2
   logic [7:0]  mem_b [64];
   logic [7:0]  ref_b [64];
   int          wait_cnt = 0;
   int          lat_sel = 0;
   int          cyc = 0;
   int          op_cnt = 0;
   int          last_hs = 0;
   logic        op_we_l   [8];
   logic [31:0] op_addr_l [8];
   logic [31:0] op_data_l [8];
   logic [1:0]  op_size_l [8];

   assign mem_ready = mem_req && (wait_cnt >= lat_sel);

   always_comb begin
      logic [5:0]  ba;
      logic [31:0] w;
      ba = mem_addr[5:0];
      w = {mem_b[ba + 6'd3], mem_b[ba + 6'd2], mem_b[ba + 6'd1], mem_b[ba]};
      case (mem_size)
         2'd0:    mem_rdata = w & 32'hFF;
         2'd1:    mem_rdata = w & 32'hFFFF;
         default: mem_rdata = w;
      endcase
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem_b[i] <= 8'(i * 37 + 5);
         wait_cnt <= 0;
      end else if (mem_req && mem_ready) begin
         wait_cnt <= 0;
         lat_sel  <= (lat_sel + 1) % 3;
         last_hs  <= cyc;
         op_we_l[op_cnt % 8]   <= mem_we;
         op_addr_l[op_cnt % 8] <= mem_addr;
         op_data_l[op_cnt % 8] <= mem_wdata;
         op_size_l[op_cnt % 8] <= mem_size;
         op_cnt <= op_cnt + 1;
         if (mem_we) begin
            mem_b[mem_addr[5:0]] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem_b[mem_addr[5:0] + 6'd1] <= mem_wdata[15:8];
            if (mem_size[1]) begin
               mem_b[mem_addr[5:0] + 6'd2] <= mem_wdata[23:16];
               mem_b[mem_addr[5:0] + 6'd3] <= mem_wdata[31:24];
            end
         end
      end else if (mem_req) begin
         wait_cnt <= wait_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_target(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] t;
      t = (a & 32'hE000_0000) | ((a & 32'h01FF_FFFF) >> 5);
      if (sz == 2'd1) t[0] = 1'b0;
      else if (sz[1]) t[1:0] = 2'b00;
      return t;
   endfunction

   function automatic logic [31:0] ref_unit(input int off, input logic [1:0] sz);
      logic [31:0] v;
      v = {ref_b[(off + 3) & 63], ref_b[(off + 2) & 63], ref_b[(off + 1) & 63], ref_b[off & 63]};
      case (sz)
         2'd0:    return v & 32'hFF;
         2'd1:    return v & 32'hFFFF;
         default: return v;
      endcase
   endfunction

   task automatic ref_store(input int off, input logic [1:0] sz, input logic [31:0] v);
      ref_b[off & 63] = v[7:0];
      if (sz != 2'd0) ref_b[(off + 1) & 63] = v[15:8];
      if (sz[1]) begin
         ref_b[(off + 2) & 63] = v[23:16];
         ref_b[(off + 3) & 63] = v[31:24];
      end
   endtask

   task automatic access(input logic [31:0] a, input logic we, input logic bv,
                         input logic [1:0] sz, output logic [31:0] data,
                         output int base, output bit timing_ok);
      int n;
      @(negedge clk);
      base      = op_cnt;
      req_valid = 1'b1;
      req_addr  = a;
      req_we    = we;
      req_wdata = 32'hA5A5_A5A4 | {31'h0, bv};
      req_size  = sz;
      n = 0;
      forever begin
         @(negedge clk);
         if (rsp_ready) break;
         n++;
         if (n > 40) break;
      end
      check(rsp_ready, "R8", "response seen", {31'h0, rsp_ready}, 32'h1);
      data = rsp_rdata;
      timing_ok = (last_hs + 1 == cyc);
      req_valid = 1'b0;
      @(negedge clk);
      check(!rsp_ready, "R8", "ready lasts one cycle", {31'h0, rsp_ready}, 32'h0);
   endtask

   task automatic do_bit(input logic [31:0] win, input int off, input int idx, input logic [1:0] sz);
      logic [31:0] a, eu, nu, tg, got;
      logic [1:0]  esz;
      logic        eb;
      int          base;
      bit          tok;
      a   = win | (32'(off) << 5) | (32'(idx) << 2) | ((idx % 2) ? 32'h3 : 32'h0);
      esz = (sz == 2'd3) ? 2'd2 : sz;
      tg  = exp_target(a, sz);
      eu  = ref_unit(off, esz);
      eb  = eu[idx];
      // read of the selected bit
      access(a, 1'b0, 1'b0, sz, got, base, tok);
      check(got == {31'h0, eb}, "R4", "read result", got, {31'h0, eb});
      check(op_cnt - base == 1 && !op_we_l[base % 8], "R4", "single downstream read",
            32'(op_cnt - base), 32'h1);
      check(op_addr_l[base % 8] == tg, "R2", "target address", op_addr_l[base % 8], tg);
      check(op_size_l[base % 8] == esz, "R3", "downstream size", 32'(op_size_l[base % 8]), 32'(esz));
      check(tok, "R8", "ready after final handshake", 32'(cyc), 32'(last_hs + 1));
      // write the inverted bit back
      nu = eu ^ (32'h1 << idx);
      access(a, 1'b1, ~eb, sz, got, base, tok);
      ref_store(off, esz, nu);
      check(got == 32'h0, "R5", "write response data", got, 32'h0);
      check(op_cnt - base == 2 && !op_we_l[base % 8] && op_we_l[(base + 1) % 8], "R7",
            "read then write-back", 32'(op_cnt - base), 32'h2);
      check(op_addr_l[(base + 1) % 8] == tg, "R7", "write-back address",
            op_addr_l[(base + 1) % 8], tg);
      check(op_data_l[(base + 1) % 8] == nu, "R6", "write-back data lanes",
            op_data_l[(base + 1) % 8], nu);
      check(tok, "R8", "ready after write-back", 32'(cyc), 32'(last_hs + 1));
   endtask

   task automatic compare_mem(input string what);
      for (int i = 0; i < 64; i++)
         check(mem_b[i] == ref_b[i], "R5", what, 32'(mem_b[i]), 32'(ref_b[i]));
   endtask

   task automatic miss(input logic [31:0] a);
      int base;
      bit seen;
      @(negedge clk);
      base = op_cnt;
      seen = 0;
      req_valid = 1'b1; req_addr = a; req_we = 1'b1; req_wdata = 32'h1; req_size = 2'd2;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rsp_ready || mem_req) seen = 1;
      end
      req_valid = 1'b0;
      check(!seen && op_cnt == base, "R1", "address outside windows ignored", a, 32'h0);
   endtask

   initial begin
      int boffs[5] = '{0, 1, 7, 13, 63};
      int hoffs[4] = '{0, 2, 30, 62};
      int woffs[3] = '{0, 4, 60};
      for (int i = 0; i < 64; i++) ref_b[i] = 8'(i * 37 + 5);
      req_valid = 1'b1;
      req_addr  = 32'h2200_0000;
      repeat (3) @(negedge clk);
      check(!rsp_ready && !mem_req, "R10", "idle during reset", {30'h0, rsp_ready, mem_req}, 32'h0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!rsp_ready && !mem_req, "R10", "idle after reset", {30'h0, rsp_ready, mem_req}, 32'h0);

      // R1 misses first, memory must stay intact
      miss(32'h21FF_FFFC);
      miss(32'h2400_0000);
      miss(32'h6200_0000);
      miss(32'h0000_0000);
      compare_mem("memory after ignored requests");

      // R3 byte sweep, both windows (R1)
      foreach (boffs[j])
         for (int b = 0; b < 8; b++)
            do_bit((b % 2) ? 32'h4200_0000 : 32'h2200_0000, boffs[j], b, 2'd0);
      compare_mem("memory after byte sweep");
      foreach (hoffs[j])
         for (int b = 0; b < 16; b++)
            do_bit((b % 2) ? 32'h2200_0000 : 32'h4200_0000, hoffs[j], b, 2'd1);
      compare_mem("memory after halfword sweep");
      foreach (woffs[j])
         for (int b = 0; b < 32; b++)
            do_bit((b % 2) ? 32'h4200_0000 : 32'h2200_0000, woffs[j], b, 2'd2);
      // size code 3 handled as word (R3)
      do_bit(32'h2200_0000, 8, 17, 2'd3);
      do_bit(32'h4200_0000, 8, 31, 2'd3);
      compare_mem("memory after word sweep");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule